// File: doc/BRIEF.md
# Programmable Row Delay Buffer

This block is a memory-backed delay line for one image row of 24-bit pixels. A free-running address counter walks a 1024-word single-port memory. On every clock the word stored at the current address is read out, and in the same cycle the incoming pixel is written to that address. The delay is not held in a register. It follows from how often the active-low `start_n` strobe returns the counter to address zero.

When `start_n` is pulsed low for one cycle every P cycles, the counter sweeps addresses 0 to P-1 over and over. Fixed pipeline stages add four more cycles, so each input pixel leaves the block P+4 clock edges after it was sampled. For a delay of N cycles, pulse the strobe every N-4 cycles. For example, a 6-cycle strobe period gives a 10-cycle row delay. If the strobe stays high long enough for the counter to reach the last address, the counter stops there and writing stops. The output then keeps presenting the word stored at that last location until the next strobe.

Top module: `row_delay_buf`

## Requirements
- R1: With `start_n` low for one edge in every P edges (1 <= P <= 1024), once P+4 edges have passed since the first strobe of that period, `dout` after each edge equals the `din` value sampled P+4 edges earlier.
- R2: While `start_n` is high and the counter is below 1023, the counter advances by exactly one per edge. A strobe period of 1024 therefore uses every address and gives a delay of 1028 without stopping.
- R3: An edge that samples `start_n` low sets the counter to zero, whatever its count. A strobe every 6 edges gives a 10-edge delay.
- R4: A read and a write to the same address on the same edge return the word stored before that edge. A strobe on every edge (P = 1) therefore gives a delay of 5.
- R5: Once the counter reaches 1023 with `start_n` high, it stays at 1023 until an edge samples `start_n` low.
- R6: While the counter is held at 1023, no word is written. From the strobe edge s onward, `dout` after edge s+1027 and after every later edge until the next strobe equals the `din` sampled at edge s+1022, whatever `din` does.
- R7: `rst_n` low clears `dout` to zero at once, without waiting for a clock edge, and returns the counter to zero.
- R8: A strobe that arrives after the counter has stopped restores normal operation: R1 holds again for the new strobe period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_n | input | 1 | Active-low strobe that returns the address counter to zero |
| din | input | 24 | Pixel entering the delay line |
| dout | output | 24 | Pixel leaving the delay line, registered |

## Verification
The checker's properties assume that `start_n` has a known value on every edge after reset. They also assume that stepping and holding depend only on the previous count and the strobe, so no particular strobe period is required. The data comparisons in the bench hold only once a strobe period has been stable for P+4 edges. For that reason, each stimulus row drives its strobe for a warm-up stretch before any comparison is counted. The strobe period stays within the memory depth, except in the one directed run that holds the strobe high on purpose to reach the stopped state.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  // Fixed latency added on top of the strobe period.
  localparam int unsigned PIPE_OFFSET  = 4;
  // Register stages after the memory read register.
  localparam int unsigned OUT_STAGES   = 1;
  // Input alignment stages, chosen so the total matches PIPE_OFFSET.
  localparam int unsigned ALIGN_STAGES = PIPE_OFFSET - OUT_STAGES;
endpackage

// File: rtl/rdb_addr_gen.sv
module rdb_addr_gen #(
  parameter  int unsigned DEPTH = 1024,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  output logic [AW-1:0] cnt,
  output logic [AW-1:0] addr_q,
  output logic          we_q
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_d;
  logic          held, held_d;
  logic          cnt_en;

  // Next-state: strobe restarts, top of range parks the counter.
  always_comb begin
    cnt_d  = cnt;
    held_d = held;
    cnt_en = 1'b1;
    if (!start_n) begin
      cnt_d  = '0;
      held_d = 1'b0;
    end else if (cnt == TOP) begin
      held_d = 1'b1;
      cnt_en = 1'b0;
    end else begin
      cnt_d  = cnt + 1'b1;
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= 1'b0;
    end else begin
      if (cnt_en) cnt <= cnt_d;
      held <= held_d;
    end
  end

  // Address stage: the write enable travels with its address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      we_q   <= 1'b1;
    end else begin
      addr_q <= cnt;
      we_q   <= ~held;
    end
  end
endmodule

// File: rtl/rdb_data_align.sv
module rdb_data_align #(
  parameter int unsigned W      = 24,
  parameter int unsigned STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe <= '0;
        end else begin
          pipe[0] <= d;
          for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rdb_mem.sv
module rdb_mem #(
  parameter  int unsigned W     = 24,
  parameter  int unsigned DEPTH = 1024,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  dout
);
  logic [W-1:0] store [DEPTH];
  logic [W-1:0] rd_q;

  // Storage array: no reset, write gated by the enable.
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  // Read register sees the word held before this edge's write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      dout <= '0;
    end else begin
      rd_q <= store[addr];
      dout <= rd_q;
    end
  end
endmodule

// File: rtl/row_delay_buf.sv
module row_delay_buf #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  import rdb_pkg::*;
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW-1:0]     cnt;
  logic [AW-1:0]     addr_q;
  logic              we_q;
  logic [DATA_W-1:0] din_al;

  rdb_addr_gen #(.DEPTH(DEPTH)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .cnt     (cnt),
    .addr_q  (addr_q),
    .we_q    (we_q)
  );

  rdb_data_align #(.W(DATA_W), .STAGES(ALIGN_STAGES)) u_align (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (din),
    .q     (din_al)
  );

  rdb_mem #(.W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr_q),
    .we    (we_q),
    .wdata (din_al),
    .dout  (dout)
  );
endmodule

// File: rtl/row_delay_buf_chk.sv
module row_delay_buf_chk #(
  parameter  int unsigned DEPTH = 1024,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_n,
  input logic [AW-1:0] cnt,
  input logic [AW-1:0] addr_q,
  input logic          we_q
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  // R3
  strobe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> cnt == '0);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);

  // R5
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && cnt == TOP) |=> cnt == TOP);

  // R6
  held_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && cnt == TOP) |-> ##2 !we_q);

  // R6
  gate_only_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |-> addr_q == TOP);

  // R1
  addr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> addr_q == $past(cnt));
endmodule

bind row_delay_buf row_delay_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_n (start_n),
  .cnt     (cnt),
  .addr_q  (addr_q),
  .we_q    (we_q)
);

// File: tb/row_delay_buf_test.sv
module row_delay_buf_test;
  localparam int DW    = 24;
  localparam int DEPTH = 1024;
  localparam int HW    = 2048;
  localparam int OFF   = 4;
  // Each row: strobe period, number of driven cycles.
  localparam int PLAN [6][2] = '{'{6, 80}, '{1, 40}, '{13, 90},
                                 '{37, 150}, '{250, 400}, '{1024, 1100}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;

  int checks = 0;
  int errors = 0;
  int ec = 0;
  bit done = 1'b0;
  logic [DW-1:0] hist [HW];

  always #4 clk = ~clk;

  row_delay_buf uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .din     (din),
    .dout    (dout)
  );

  // Record every sampled input, indexed by edge number.
  always @(posedge clk) begin
    hist[ec % HW] <= din;
    ec <= ec + 1;
  end

  function automatic logic [DW-1:0] pat(int k);
    return DW'((k * 32'h0001_0F13) ^ 32'h00A5_5A3C);
  endfunction

  function automatic logic [DW-1:0] sampled_at(int e);
    return hist[e % HW];
  endfunction

  task automatic chk(logic [DW-1:0] act, logic [DW-1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Periodic strobe with a ramp on din; compare after warm-up.
  task automatic run_period(int p, int ncyc, string req);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (i >= p + OFF + 2) chk(dout, sampled_at(ec - 1 - (p + OFF)), req);
      start_n = (i % p == 0) ? 1'b0 : 1'b1;
      din     = pat(ec);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int s;
    rst_n   = 1'b0;
    start_n = 1'b1;
    din     = '0;
    // R7: output cleared while reset is held
    repeat (3) begin
      @(negedge clk);
      chk(dout, '0, "R7");
    end
    rst_n = 1'b1;

    // Stimulus table: period and expected delay of period plus four
    for (int r = 0; r < 6; r++) begin
      string tag;
      if (PLAN[r][0] == 1)          tag = "R4";
      else if (PLAN[r][0] == 6)     tag = "R3";
      else if (PLAN[r][0] == DEPTH) tag = "R2";
      else                          tag = "R1";
      run_period(PLAN[r][0], PLAN[r][1], tag);
    end

    // R5 / R6: one strobe, then hold high until the counter parks
    @(negedge clk);
    s       = ec;
    start_n = 1'b0;
    din     = pat(ec);
    for (int i = 0; i < DEPTH + 80; i++) begin
      @(negedge clk);
      if (ec - 1 >= s + DEPTH + 3)
        chk(dout, sampled_at(s + DEPTH - 2), "R6");
      start_n = 1'b1;
      din     = pat(ec) ^ 24'hFFFFFF;
    end

    // R8: strobe after parking restores the delay
    run_period(9, 60, "R8");

    // R7: asynchronous clear in mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(dout, '0, "R7");
    @(negedge clk);
    chk(dout, '0, "R7");
    rst_n = 1'b1;
    run_period(5, 40, "R1");

    summary();
  end
endmodule